// File: doc/BRIEF.md
# Micro-Controlled 8-bit Shift ALU

This block is the arithmetic and shift unit of a small microcoded datapath. There is no opcode field. A microcode word drives a set of independent control bits on every cycle: add, and, xor, right-operand invert, forced carry-in, shift, shift direction, roll and arithmetic fill. Combinations of these bits yield add, subtract, compare, increment, decrement, xor, and-not, move, and five shift and rotate forms. The unit computes a result and a carry-out from a left operand, a right operand and a carry input. The result, the carry flag and the Negative/Zero flag pair each go into their own register, and each register has its own save enable.

An operation takes effect on a clock edge where `run` is high. `clear` wipes the result register and all flags, and it overrides `run`. Compare is a subtract issued with the result save enable low, so only the flags change. The datapath width is a parameter with a default of 8, and a parameter picks between two adder structures.

Top module: `ucode_alu`

## Requirements
- R1: After reset, and on the edge after any cycle with `clear` high, `res_q` is 0 and `cy_q`, `neg_q` and `zero_q` are all 0. `clear` wins over `run`.
- R2: The select priority is shift, then add, then xor, then and, and if none of these is set the value is zero. Add computes lhs + rhs' + c. Here rhs' is the right operand, inverted when `inv_rhs` is 1, and c is 1 when `force_cin` is 1 and otherwise `cin`. The carry-out is bit 8 of that sum.
- R3: With `op_add`, `inv_rhs` and `force_cin` set, the result is lhs − rhs and carry-out is 1 exactly when no borrow occurs. Compare is the same operation with `save_res` low, which leaves `res_q` unchanged while the flags update.
- R4: Increment (add, `force_cin`, rhs = 0) gives lhs + 1, and wrapping from all-ones sets carry.
- R5: Decrement (add, `inv_rhs`, rhs = 0, `cin` = 0, no `force_cin`) gives lhs − 1. Carry is 0 only when lhs was 0.
- R6: And-not (`op_and` with `inv_rhs`) gives lhs & ~rhs with carry-out 0.
- R7: Xor (`op_xor`) gives lhs ^ rhs with carry-out 0.
- R8: Move (add with rhs = 0, `cin` = 0) copies lhs unchanged to the result.
- R9: Shift left (`op_shift` alone) fills bit 0 with 0. Shift right (`op_shift`, `sh_right`) fills the MSB with 0. The bit shifted out always becomes the carry-out.
- R10: Rotate left (`sh_roll`) and rotate right (`sh_right`, `sh_roll`) move the bit that leaves one end into the vacated bit at the other end. That same bit is also the carry-out, and the incoming carry is not used.
- R11: Arithmetic shift right (`sh_right`, `sh_arith`) keeps the MSB and puts the old bit 0 in carry-out.
- R12: When `save_nz` is set, `neg_q` takes the MSB of the computed value and `zero_q` is 1 exactly when that value is zero.
- R13: `save_res`, `save_nz` and `save_cy` each gate only their own register. With `run` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of result and flags |
| run | input | 1 | Execute the operation this cycle |
| lhs | input | WIDTH | Left operand |
| rhs | input | WIDTH | Right operand |
| cin | input | 1 | Carry input to the adder |
| op_add | input | 1 | Select adder path |
| op_and | input | 1 | Select AND path |
| op_xor | input | 1 | Select XOR path |
| inv_rhs | input | 1 | Invert right operand |
| force_cin | input | 1 | Force adder carry-in to 1 |
| op_shift | input | 1 | Select shifter path |
| sh_right | input | 1 | Shift direction right |
| sh_roll | input | 1 | Rotate instead of zero fill |
| sh_arith | input | 1 | Sign fill on right shift |
| save_res | input | 1 | Write the result register |
| save_nz | input | 1 | Write the N and Z flags |
| save_cy | input | 1 | Write the carry flag |
| res_q | output | WIDTH | Result register |
| cy_q | output | 1 | Carry flag |
| neg_q | output | 1 | Negative flag |
| zero_q | output | 1 | Zero flag |

## Verification
The bench goes after the carry edges. Subtract of 0 − 1 must clear carry while 16 − 1 sets it, and increment from all-ones must wrap to zero with carry set. An inverted carry sense or a dropped carry-in would flip these. The bit-fill corners come next: a rotate that brings carry in instead of the outgoing bit, or an arithmetic shift that loses the sign, gives a wrong MSB or LSB on patterns such as 0x81 and 0x82. Compare with the result save low, and cycles with `run` low, must leave `res_q` untouched, which catches enables that leak across registers. Random control mixes also test the select priority.

// File: rtl/ucode_alu_pkg.sv
package ucode_alu_pkg;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_AND   = 3'd1,
      SEL_XOR   = 3'd2,
      SEL_ADD   = 3'd3,
      SEL_SHIFT = 3'd4
   } alu_sel_e;

   // Priority among the path-select bits: shift, add, xor, and.
   function automatic alu_sel_e pick_path(input logic shift_b, input logic add_b,
                                          input logic xor_b, input logic and_b);
      if (shift_b)    return SEL_SHIFT;
      else if (add_b) return SEL_ADD;
      else if (xor_b) return SEL_XOR;
      else if (and_b) return SEL_AND;
      else            return SEL_NONE;
   endfunction

endpackage

// File: rtl/ucode_alu_adder.sv
module ucode_alu_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             ci,
   output logic [WIDTH-1:0] sum,
   output logic             co
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = ci;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ chain[i];
            assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
         end
         assign co = chain[WIDTH];
      end else begin : g_flat
         assign {co, sum} = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};
      end
   endgenerate
endmodule

// File: rtl/ucode_alu_logic.sv
module ucode_alu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             use_xor,
   output logic [WIDTH-1:0] y
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign y[i] = use_xor ? (a[i] ^ b[i]) : (a[i] & b[i]);
      end
   endgenerate
endmodule

// File: rtl/ucode_alu_shifter.sv
module ucode_alu_shifter #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic             right,
   input  logic             roll,
   input  logic             arith,
   output logic [WIDTH-1:0] y,
   output logic             co
);
   localparam int MSB = WIDTH - 1;

   logic fill_hi;
   logic fill_lo;

   always_comb begin
      fill_hi = roll ? a[0] : (arith ? a[MSB] : 1'b0);
      fill_lo = roll ? a[MSB] : 1'b0;
      if (right) begin
         y  = {fill_hi, a[MSB:1]};
         co = a[0];
      end else begin
         y  = {a[MSB-1:0], fill_lo};
         co = a[MSB];
      end
   end
endmodule

// File: rtl/ucode_alu.sv
module ucode_alu #(
   parameter int WIDTH        = 8,
   parameter bit ADDER_RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic             cin,
   input  logic             op_add,
   input  logic             op_and,
   input  logic             op_xor,
   input  logic             inv_rhs,
   input  logic             force_cin,
   input  logic             op_shift,
   input  logic             sh_right,
   input  logic             sh_roll,
   input  logic             sh_arith,
   input  logic             save_res,
   input  logic             save_nz,
   input  logic             save_cy,
   output logic [WIDTH-1:0] res_q,
   output logic             cy_q,
   output logic             neg_q,
   output logic             zero_q
);
   import ucode_alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ucode_alu: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] rhs_eff;
   logic             add_ci;
   logic [WIDTH-1:0] add_y, log_y, sh_y;
   logic             add_co, sh_co;
   logic [WIDTH-1:0] val;
   logic             val_co;
   alu_sel_e         sel;

   assign rhs_eff = inv_rhs ? ~rhs : rhs;
   assign add_ci  = force_cin | cin;
   assign sel     = pick_path(op_shift, op_add, op_xor, op_and);

   ucode_alu_adder #(.WIDTH(WIDTH), .RIPPLE(ADDER_RIPPLE)) u_add (
      .a(lhs), .b(rhs_eff), .ci(add_ci), .sum(add_y), .co(add_co)
   );

   ucode_alu_logic #(.WIDTH(WIDTH)) u_log (
      .a(lhs), .b(rhs_eff), .use_xor(op_xor), .y(log_y)
   );

   ucode_alu_shifter #(.WIDTH(WIDTH)) u_sh (
      .a(lhs), .right(sh_right), .roll(sh_roll), .arith(sh_arith),
      .y(sh_y), .co(sh_co)
   );

   always_comb begin
      unique case (sel)
         SEL_SHIFT: begin val = sh_y;  val_co = sh_co;  end
         SEL_ADD:   begin val = add_y; val_co = add_co; end
         SEL_XOR,
         SEL_AND:   begin val = log_y; val_co = 1'b0;   end
         default:   begin val = '0;    val_co = 1'b0;   end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         cy_q   <= 1'b0;
         neg_q  <= 1'b0;
         zero_q <= 1'b0;
      end else if (clear) begin
         res_q  <= '0;
         cy_q   <= 1'b0;
         neg_q  <= 1'b0;
         zero_q <= 1'b0;
      end else if (run) begin
         if (save_res) res_q <= val;
         if (save_cy)  cy_q  <= val_co;
         if (save_nz) begin
            neg_q  <= val[MSB];
            zero_q <= (val == '0);
         end
      end
   end
endmodule

// File: rtl/ucode_alu_chk.sv
module ucode_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             run,
   input logic [WIDTH-1:0] lhs,
   input logic [WIDTH-1:0] rhs,
   input logic             op_add,
   input logic             inv_rhs,
   input logic             force_cin,
   input logic             op_shift,
   input logic             sh_right,
   input logic             sh_roll,
   input logic             save_res,
   input logic             save_nz,
   input logic             save_cy,
   input logic [WIDTH-1:0] res_q,
   input logic             cy_q,
   input logic             neg_q,
   input logic             zero_q
);
   localparam int MSB = WIDTH - 1;

   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (res_q == '0) && !cy_q && !neg_q && !zero_q);

   assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !run) |=> $stable(res_q) && $stable(cy_q) && $stable(neg_q) && $stable(zero_q));

   assert_compare_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && run && !save_res) |=> $stable(res_q));

   assert_nz_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && run && save_res && save_nz) |=> (zero_q == (res_q == '0)) && (neg_q == res_q[MSB]));

   assert_rotl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && run && save_res && op_shift && !sh_right && sh_roll)
      |=> res_q == {$past(lhs[MSB-1:0]), $past(lhs[MSB])});

   assert_shift_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && run && save_cy && op_shift)
      |=> cy_q == ($past(sh_right) ? $past(lhs[0]) : $past(lhs[MSB])));

   assert_increment_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && run && save_res && !op_shift && op_add && force_cin && !inv_rhs && rhs == '0)
      |=> res_q == $past(lhs) + WIDTH'(1));
endmodule

bind ucode_alu ucode_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .run(run), .lhs(lhs), .rhs(rhs),
   .op_add(op_add), .inv_rhs(inv_rhs), .force_cin(force_cin), .op_shift(op_shift),
   .sh_right(sh_right), .sh_roll(sh_roll), .save_res(save_res), .save_nz(save_nz),
   .save_cy(save_cy), .res_q(res_q), .cy_q(cy_q), .neg_q(neg_q), .zero_q(zero_q)
);

// File: tb/ucode_alu_test.sv
`timescale 1ns/1ps
module ucode_alu_test;
   // control word layout used only inside the bench
   localparam logic [8:0] C_ADD = 9'h001, C_AND = 9'h002, C_XOR = 9'h004,
                          C_INV = 9'h008, C_FCI = 9'h010, C_SH  = 9'h020,
                          C_R   = 9'h040, C_ROL = 9'h080, C_AR  = 9'h100;
   localparam logic [2:0] S_ALL = 3'b111, S_RES = 3'b100, S_NZ = 3'b010, S_CY = 3'b001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear = 1'b0, run = 1'b0, cin = 1'b0;
   logic [7:0] lhs = '0, rhs = '0;
   logic [8:0] ctl = '0;
   logic [2:0] sv = '0;
   logic [7:0] res_q;
   logic cy_q, neg_q, zero_q;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   logic [7:0] m_res = '0;
   logic m_cy = 1'b0, m_n = 1'b0, m_z = 1'b0;

   always #5 clk = ~clk;

   ucode_alu uut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .run(run), .lhs(lhs), .rhs(rhs), .cin(cin),
      .op_add(ctl[0]), .op_and(ctl[1]), .op_xor(ctl[2]), .inv_rhs(ctl[3]),
      .force_cin(ctl[4]), .op_shift(ctl[5]), .sh_right(ctl[6]), .sh_roll(ctl[7]),
      .sh_arith(ctl[8]), .save_res(sv[2]), .save_nz(sv[1]), .save_cy(sv[0]),
      .res_q(res_q), .cy_q(cy_q), .neg_q(neg_q), .zero_q(zero_q)
   );

   function automatic logic [8:0] ref_calc(input logic [8:0] c, input logic [7:0] a,
                                           input logic [7:0] b, input logic ci);
      logic [7:0] bb, y;
      logic cy;
      int t;
      bb = c[3] ? ~b : b;
      y = '0; cy = 1'b0;
      if (c[5]) begin
         if (c[6]) begin
            y = a >> 1;
            y[7] = c[7] ? a[0] : (c[8] ? a[7] : 1'b0);
            cy = a[0];
         end else begin
            y = a << 1;
            y[0] = c[7] ? a[7] : 1'b0;
            cy = a[7];
         end
      end else if (c[0]) begin
         t = int'(a) + int'(bb) + ((c[4] || ci) ? 1 : 0);
         y = t[7:0]; cy = t[8];
      end else if (c[2]) y = a ^ bb;
      else if (c[1]) y = a & bb;
      return {cy, y};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk({tag, " res"}, res_q, m_res);
      chk({tag, " cy"}, cy_q, m_cy);
      chk({tag, " neg"}, neg_q, m_n);
      chk({tag, " zero"}, zero_q, m_z);
   endtask

   task automatic op(input logic [8:0] c, input logic [2:0] s, input logic [7:0] a,
                     input logic [7:0] b, input logic ci, input logic r, input logic clr);
      logic [8:0] o;
      ctl = c; sv = s; lhs = a; rhs = b; cin = ci; run = r; clear = clr;
      o = ref_calc(c, a, b, ci);
      if (clr) begin
         m_res = '0; m_cy = 0; m_n = 0; m_z = 0;
      end else if (r) begin
         if (s[2]) m_res = o[7:0];
         if (s[0]) m_cy = o[8];
         if (s[1]) begin m_n = o[7]; m_z = (o[7:0] == 8'h00); end
      end
      @(posedge clk);
      @(negedge clk);
      run = 1'b0; clear = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);

      op(C_ADD, S_ALL, 8'hF0, 8'h20, 1'b1, 1, 0);
      chk("R2 add res", res_q, 8'h11); chk("R2 add cy", cy_q, 1);
      op(C_ADD | C_INV | C_FCI, S_ALL, 8'h10, 8'h01, 0, 1, 0);
      chk("R3 sub res", res_q, 8'h0F); chk("R3 sub noborrow", cy_q, 1);
      op(C_ADD | C_INV | C_FCI, S_ALL, 8'h00, 8'h01, 0, 1, 0);
      chk("R3 sub wrap", res_q, 8'hFF); chk("R3 borrow", cy_q, 0); chk("R12 neg", neg_q, 1);
      op(C_ADD | C_INV | C_FCI, S_NZ | S_CY, 8'h05, 8'h05, 0, 1, 0);
      chk("R3 cmp keeps res", res_q, 8'hFF); chk("R3 cmp zero", zero_q, 1); chk("R3 cmp cy", cy_q, 1);
      op(C_ADD | C_FCI, S_ALL, 8'hFF, 8'h00, 0, 1, 0);
      chk("R4 inc res", res_q, 8'h00); chk("R4 inc cy", cy_q, 1); chk("R12 zero", zero_q, 1);
      op(C_ADD | C_INV, S_ALL, 8'h00, 8'h00, 0, 1, 0);
      chk("R5 dec 0", res_q, 8'hFF); chk("R5 dec 0 cy", cy_q, 0);
      op(C_ADD | C_INV, S_ALL, 8'h01, 8'h00, 0, 1, 0);
      chk("R5 dec 1", res_q, 8'h00); chk("R5 dec 1 cy", cy_q, 1);
      op(C_AND | C_INV, S_ALL, 8'hF3, 8'h31, 1, 1, 0);
      chk("R6 andnot", res_q, 8'hC2); chk("R6 cy", cy_q, 0);
      op(C_XOR, S_ALL, 8'hAA, 8'h0F, 0, 1, 0);
      chk("R7 xor", res_q, 8'hA5);
      op(C_ADD, S_ALL, 8'h80, 8'h00, 0, 1, 0);
      chk("R8 move", res_q, 8'h80); chk("R8 neg", neg_q, 1);
      op(C_SH, S_ALL, 8'h81, 8'h00, 0, 1, 0);
      chk("R9 shl", res_q, 8'h02); chk("R9 shl cy", cy_q, 1);
      op(C_SH | C_R, S_ALL, 8'h81, 8'h00, 0, 1, 0);
      chk("R9 shr", res_q, 8'h40); chk("R9 shr cy", cy_q, 1);
      op(C_SH | C_ROL, S_ALL, 8'h81, 8'h00, 0, 1, 0);
      chk("R10 rol", res_q, 8'h03);
      op(C_SH | C_R | C_ROL, S_ALL, 8'h01, 8'h00, 0, 1, 0);
      chk("R10 ror", res_q, 8'h80); chk("R10 ror cy", cy_q, 1);
      op(C_SH | C_R | C_AR, S_ALL, 8'h82, 8'h00, 1, 1, 0);
      chk("R11 sra neg", res_q, 8'hC1); chk("R11 sra cy", cy_q, 0);
      op(C_SH | C_R | C_AR, S_ALL, 8'h42, 8'h00, 0, 1, 0);
      chk("R11 sra pos", res_q, 8'h21);
      op(C_SH | C_ADD, S_ALL, 8'h11, 8'h22, 0, 1, 0);
      chk("R2 shift wins", res_q, 8'h22);
      op(C_ADD, S_ALL, 8'h55, 8'h11, 0, 0, 0);
      chk("R13 idle res", res_q, 8'h22);
      op(C_ADD, S_CY, 8'hFF, 8'h01, 0, 1, 0);
      chk("R13 cy only res", res_q, 8'h22); chk("R13 cy only", cy_q, 1);
      op(C_ADD, S_ALL, 8'h55, 8'h11, 0, 1, 1);
      chk_all("R1 clear");
      chk("R1 clear res", res_q, 8'h00);

      for (int i = 0; i < 3000; i++) begin
         op(9'($urandom), 3'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
            ($urandom % 8) != 0, ($urandom % 40) == 0);
         chk_all("R12 random");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule